// File: doc/BRIEF.md
# Pin Edge and Level Interrupt Controller

This block turns a group of already-routed input lines into per-line interrupt requests. Each channel has its own input bit. The input first passes through a short flop chain that brings it into the clock domain. The channel then either watches for transitions or tests the line against a chosen active level. Software controls the block through a flat 32-bit register window. Each channel owns bit n of every register, and only the low channel bits exist.

A channel in edge mode always records rising and falling transitions in two detect registers, whatever its enables are. It raises its request only when a recorded transition matches a direction that software has enabled. A channel in level mode uses one enable bit to switch it on and the other to pick the active polarity. Its request then tracks the synchronized line for as long as the line sits at that polarity.

Both enable registers can be written directly. They also have a write-ones-to-set alias and a write-ones-to-clear alias, so one channel can be changed without a read-modify-write. There are no data streams here, so every pin is plain control or status and no valid/ready handshake is used.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset, every register reads zero and every interrupt output is low.
- R2: The mode register at offset 0x00 stores bits 7:0 and reads zero above them. Bit value 0 selects edge mode for the channel and 1 selects level mode.
- R3: The first enable register (offset 0x04) and the second enable register (offset 0x10) are each writable directly. Each also has a set alias and a clear alias: 0x08 sets and 0x0C clears the first, and 0x14 sets and 0x18 clears the second. A one bit in an alias write changes the matching enable bit, a zero bit leaves it unchanged, and an alias always reads zero.
- R4: The rising-detect register (offset 0x1C) sets bit n on a 0-to-1 transition of synchronized input n, whatever the enables and mode are. The bit can be read at the third clock edge after the input changes, and writing 1 to the bit clears it.
- R5: The falling-detect register (offset 0x20) sets bit n on a 1-to-0 transition with the same latency and clears on a write of 1.
- R6: In edge mode, status bit n (offset 0x24) and interrupt output n are high when (rising-detect AND first enable) OR (falling-detect AND second enable) is true for that channel.
- R7: In edge mode, writing 1 to status bit n clears both detect bits of channel n. Zero bits in that write have no effect.
- R8: In level mode, status bit n and interrupt output n equal first-enable AND (synchronized input equals second-enable bit), where a second-enable value of 1 means active high and 0 means active low.
- R9: In level mode, writing 1 to status bit n inverts the second-enable bit of channel n and leaves both detect bits unchanged.
- R10: When a transition is recorded in the same cycle as a software clear of that detect bit, through the detect register or through the status register, the bit ends up set.
- R11: Reads of an unmapped offset return zero, and writes to one change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_CH | Raw channel input lines |
| bus_we | input | 1 | Register write strobe, sampled at the clock edge |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| irq_o | output | NUM_CH | Per-channel interrupt requests, equal to the status bits |

## Verification
The bench builds the block with its default parameters: eight channels, a two-stage synchronizer, an 8-bit offset and a 32-bit data path. With these values every channel can be swept.

In edge mode, the bench tries all four enable combinations on every channel. It fires one rising edge and one falling edge on the walked channel and derives the expected detect, status and interrupt values arithmetically. In level mode, it crosses both polarity settings and two enable masks with several input patterns.

The two-flop latency is known, so the bench can place a software clear exactly in the cycle where a transition is recorded. This exercises the case where the new edge and the clear collide.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

  // Byte offsets of the register window
  localparam logic [7:0] OFF_MODE     = 8'h00;
  localparam logic [7:0] OFF_EN_A     = 8'h04;
  localparam logic [7:0] OFF_EN_A_SET = 8'h08;
  localparam logic [7:0] OFF_EN_A_CLR = 8'h0C;
  localparam logic [7:0] OFF_EN_B     = 8'h10;
  localparam logic [7:0] OFF_EN_B_SET = 8'h14;
  localparam logic [7:0] OFF_EN_B_CLR = 8'h18;
  localparam logic [7:0] OFF_RDET     = 8'h1C;
  localparam logic [7:0] OFF_FDET     = 8'h20;
  localparam logic [7:0] OFF_STAT     = 8'h24;

  typedef enum logic {
    MODE_EDGE  = 1'b0,
    MODE_LEVEL = 1'b1
  } chan_mode_e;

  // Per-channel write controls produced by the decoder
  typedef struct packed {
    logic mode_we;
    logic mode_wd;
    logic en_a_set;
    logic en_a_clr;
    logic en_b_set;
    logic en_b_clr;
    logic rdet_clr;
    logic fdet_clr;
    logic stat_wr;
  } chan_ctl_t;

endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[LAST];
endmodule

// File: rtl/pin_irq_regs.sv
module pin_irq_regs
  import pin_irq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_CH-1:0] mode_q,
  input  logic [NUM_CH-1:0] en_a_q,
  input  logic [NUM_CH-1:0] en_b_q,
  input  logic [NUM_CH-1:0] rdet_q,
  input  logic [NUM_CH-1:0] fdet_q,
  input  logic [NUM_CH-1:0] stat_q,
  output chan_ctl_t         ctl_o [NUM_CH]
);
  logic [NUM_CH-1:0] wd;
  assign wd = bus_wdata[NUM_CH-1:0];

  generate
    if (DATA_W > NUM_CH) begin : g_unused
      logic unused_hi;
      assign unused_hi = ^bus_wdata[DATA_W-1:NUM_CH];
    end
  endgenerate

  logic hit_mode, hit_a, hit_a_set, hit_a_clr, hit_b, hit_b_set, hit_b_clr;
  logic hit_rdet, hit_fdet, hit_stat, hit_any;

  assign hit_mode  = (bus_addr == ADDR_W'(OFF_MODE));
  assign hit_a     = (bus_addr == ADDR_W'(OFF_EN_A));
  assign hit_a_set = (bus_addr == ADDR_W'(OFF_EN_A_SET));
  assign hit_a_clr = (bus_addr == ADDR_W'(OFF_EN_A_CLR));
  assign hit_b     = (bus_addr == ADDR_W'(OFF_EN_B));
  assign hit_b_set = (bus_addr == ADDR_W'(OFF_EN_B_SET));
  assign hit_b_clr = (bus_addr == ADDR_W'(OFF_EN_B_CLR));
  assign hit_rdet  = (bus_addr == ADDR_W'(OFF_RDET));
  assign hit_fdet  = (bus_addr == ADDR_W'(OFF_FDET));
  assign hit_stat  = (bus_addr == ADDR_W'(OFF_STAT));
  assign hit_any   = hit_mode | hit_a | hit_a_set | hit_a_clr | hit_b |
                     hit_b_set | hit_b_clr | hit_rdet | hit_fdet | hit_stat;

  // Direct enable writes become a set/clear pair so channels see one form
  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ctl
      assign ctl_o[i].mode_we  = bus_we & hit_mode;
      assign ctl_o[i].mode_wd  = wd[i];
      assign ctl_o[i].en_a_set = bus_we & ((hit_a & wd[i]) | (hit_a_set & wd[i]));
      assign ctl_o[i].en_a_clr = bus_we & ((hit_a & ~wd[i]) | (hit_a_clr & wd[i]));
      assign ctl_o[i].en_b_set = bus_we & ((hit_b & wd[i]) | (hit_b_set & wd[i]));
      assign ctl_o[i].en_b_clr = bus_we & ((hit_b & ~wd[i]) | (hit_b_clr & wd[i]));
      assign ctl_o[i].rdet_clr = bus_we & hit_rdet & wd[i];
      assign ctl_o[i].fdet_clr = bus_we & hit_fdet & wd[i];
      assign ctl_o[i].stat_wr  = bus_we & hit_stat & wd[i];

      AST_SET_CLR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctl_o[i].en_a_set, ctl_o[i].en_a_clr, ctl_o[i].en_b_set, ctl_o[i].en_b_clr})); // R3
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    if (hit_mode)      bus_rdata[NUM_CH-1:0] = mode_q;
    else if (hit_a)    bus_rdata[NUM_CH-1:0] = en_a_q;
    else if (hit_b)    bus_rdata[NUM_CH-1:0] = en_b_q;
    else if (hit_rdet) bus_rdata[NUM_CH-1:0] = rdet_q;
    else if (hit_fdet) bus_rdata[NUM_CH-1:0] = fdet_q;
    else if (hit_stat) bus_rdata[NUM_CH-1:0] = stat_q;
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_any |-> (bus_rdata == '0)); // R11
  AST_ALIAS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_a_set | hit_a_clr | hit_b_set | hit_b_clr) |-> (bus_rdata == '0)); // R3
endmodule

// File: rtl/pin_irq_chan.sv
module pin_irq_chan
  import pin_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin_s,
  input  chan_ctl_t ctl,
  output logic      mode_o,
  output logic      en_a_o,
  output logic      en_b_o,
  output logic      rdet_o,
  output logic      fdet_o,
  output logic      pend_o
);
  chan_mode_e mode_q;
  logic       prev_q, en_a_q, en_b_q, rdet_q, fdet_q;
  logic       rise_ev, fall_ev, edge_clr, lvl_toggle;

  assign rise_ev    = pin_s & ~prev_q;
  assign fall_ev    = ~pin_s & prev_q;
  assign edge_clr   = ctl.stat_wr & (mode_q == MODE_EDGE);
  assign lvl_toggle = ctl.stat_wr & (mode_q == MODE_LEVEL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_EDGE;
      prev_q <= 1'b0;
      en_a_q <= 1'b0;
      en_b_q <= 1'b0;
      rdet_q <= 1'b0;
      fdet_q <= 1'b0;
    end else begin
      prev_q <= pin_s;
      if (ctl.mode_we) mode_q <= chan_mode_e'(ctl.mode_wd);
      if (ctl.en_a_set)      en_a_q <= 1'b1;
      else if (ctl.en_a_clr) en_a_q <= 1'b0;
      if (lvl_toggle)        en_b_q <= ~en_b_q;
      else if (ctl.en_b_set) en_b_q <= 1'b1;
      else if (ctl.en_b_clr) en_b_q <= 1'b0;
      // a fresh transition outranks any clear in the same cycle
      rdet_q <= rise_ev | (rdet_q & ~(ctl.rdet_clr | edge_clr));
      fdet_q <= fall_ev | (fdet_q & ~(ctl.fdet_clr | edge_clr));
    end
  end

  always_comb begin
    if (mode_q == MODE_LEVEL) pend_o = en_a_q & (pin_s == en_b_q);
    else                      pend_o = (rdet_q & en_a_q) | (fdet_q & en_b_q);
  end

  assign mode_o = mode_q;
  assign en_a_o = en_a_q;
  assign en_b_o = en_b_q;
  assign rdet_o = rdet_q;
  assign fdet_o = fdet_q;

  AST_RISE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    rise_ev |=> rdet_q); // R10
  AST_FALL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    fall_ev |=> fdet_q); // R10
  AST_RDET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rdet_q && !ctl.rdet_clr && !ctl.stat_wr) |=> rdet_q); // R4
  AST_LEVEL_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_toggle |=> (en_b_q != $past(en_b_q))); // R9
  AST_LEVEL_KEEPS_DET: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_toggle && rdet_q && !ctl.rdet_clr) |=> rdet_q); // R9
  AST_QUIET_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_a_q && !en_b_q) |-> !pend_o); // R6
  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.en_a_set && !ctl.en_a_clr) |=> en_a_q); // R3
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pin_irq_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] pin_i,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] irq_o
);
  logic [NUM_CH-1:0] pin_s;
  logic [NUM_CH-1:0] mode_v, en_a_v, en_b_v, rdet_v, fdet_v, pend_v;
  chan_ctl_t         ctl [NUM_CH];

  pin_irq_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(pin_s)
  );

  pin_irq_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mode_q(mode_v), .en_a_q(en_a_v), .en_b_q(en_b_v),
    .rdet_q(rdet_v), .fdet_q(fdet_v), .stat_q(pend_v),
    .ctl_o(ctl)
  );

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      pin_irq_chan u_chan (
        .clk(clk), .rst_n(rst_n), .pin_s(pin_s[i]), .ctl(ctl[i]),
        .mode_o(mode_v[i]), .en_a_o(en_a_v[i]), .en_b_o(en_b_v[i]),
        .rdet_o(rdet_v[i]), .fdet_o(fdet_v[i]), .pend_o(pend_v[i])
      );
    end
  endgenerate

  assign irq_o = pend_v;

  AST_RESET_IRQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq_o == '0)); // R1
endmodule

// File: tb/tb_pin_irq_ctrl.sv
module tb_pin_irq_ctrl;
  localparam int NCH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pins = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  irq;

  int total = 0;
  int fails = 0;

  always #10 clk = ~clk;

  pin_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pins), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rdchk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic drive(input logic [7:0] v);
    @(negedge clk);
    pins = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] exp_s, mask, ena, enb, p;
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: reset state on every mapped offset and on the outputs
    for (int a = 0; a <= 8'h24; a += 4) rdchk("R1", 8'(a), 32'h0);
    chk("R1 irq", {24'h0, irq}, 32'h0);

    // R2: mode register width
    wr(8'h00, 32'hFFFF_FFA5);
    rdchk("R2", 8'h00, 32'h0000_00A5);
    wr(8'h00, 32'h0);

    // R3: direct writes and aliases
    wr(8'h08, 32'h0F); rdchk("R3 set", 8'h04, 32'h0F);
    wr(8'h08, 32'h30); rdchk("R3 set keeps", 8'h04, 32'h3F);
    wr(8'h0C, 32'h05); rdchk("R3 clr", 8'h04, 32'h3A);
    rdchk("R3 alias read", 8'h08, 32'h0);
    rdchk("R3 alias read", 8'h0C, 32'h0);
    wr(8'h14, 32'hC3); wr(8'h18, 32'h41); rdchk("R3 b", 8'h10, 32'h82);
    rdchk("R3 alias read", 8'h14, 32'h0);
    rdchk("R3 alias read", 8'h18, 32'h0);
    wr(8'h04, 32'h0); wr(8'h10, 32'h0);
    rdchk("R3 direct", 8'h04, 32'h0);

    // R4/R5: detect registers and write-one clear
    drive(8'hFF); rdchk("R4 all", 8'h1C, 32'hFF);
    drive(8'h00); rdchk("R5 all", 8'h20, 32'hFF);
    wr(8'h1C, 32'h0F); rdchk("R4 clear", 8'h1C, 32'hF0);
    wr(8'h20, 32'hF0); rdchk("R5 clear", 8'h20, 32'h0F);
    wr(8'h1C, 32'hFF); wr(8'h20, 32'hFF);

    // R6/R7: edge sweep, every channel under all four enable combinations
    for (int combo = 0; combo < 4; combo++) begin
      ena = combo[0] ? 8'hFF : 8'h00;
      enb = combo[1] ? 8'hFF : 8'h00;
      wr(8'h04, {24'h0, ena}); wr(8'h10, {24'h0, enb});
      for (int ch = 0; ch < NCH; ch++) begin
        mask = 8'(1 << ch);
        drive(mask);
        rdchk("R4 walk", 8'h1C, {24'h0, mask});
        exp_s = mask & ena;
        rdchk("R6 rise", 8'h24, {24'h0, exp_s});
        chk("R6 irq", {24'h0, irq}, {24'h0, exp_s});
        drive(8'h00);
        rdchk("R5 walk", 8'h20, {24'h0, mask});
        exp_s = mask & (ena | enb);
        rdchk("R6 both", 8'h24, {24'h0, exp_s});
        wr(8'h24, 32'h0);
        rdchk("R7 zero write", 8'h1C, {24'h0, mask});
        wr(8'h24, {24'h0, mask});
        rdchk("R7 clr rise", 8'h1C, 32'h0);
        rdchk("R7 clr fall", 8'h20, 32'h0);
        chk("R7 irq", {24'h0, irq}, 32'h0);
      end
    end

    // R8: level sweep over polarity, enable mask and input pattern
    wr(8'h00, 32'hFF);
    for (int pol = 0; pol < 2; pol++) begin
      for (int em = 0; em < 2; em++) begin
        ena = em ? 8'h3C : 8'hFF;
        enb = pol ? 8'hFF : 8'h00;
        wr(8'h04, {24'h0, ena}); wr(8'h10, {24'h0, enb});
        for (int k = 0; k < 4; k++) begin
          p = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : (k == 2) ? 8'h5A : 8'hC3;
          drive(p);
          exp_s = ena & ~(p ^ enb);
          rdchk("R8", 8'h24, {24'h0, exp_s});
          chk("R8 irq", {24'h0, irq}, {24'h0, exp_s});
        end
      end
    end

    // R9: status write in level mode inverts polarity, keeps detects
    drive(8'h00);
    rd(8'h1C, v);
    wr(8'h10, 32'h0);
    wr(8'h24, 32'h0F);
    rdchk("R9 toggle", 8'h10, 32'h0F);
    wr(8'h24, 32'h03);
    rdchk("R9 toggle back", 8'h10, 32'h0C);
    rdchk("R9 det kept", 8'h1C, v);
    chk("R9 nonzero det", {31'h0, v != 0}, 32'h1);

    // R10: edge and clear land on the same clock edge
    wr(8'h00, 32'h0); wr(8'h10, 32'h01);
    wr(8'h1C, 32'hFF); wr(8'h20, 32'hFF);
    @(negedge clk); pins = 8'h01;
    @(posedge clk); @(posedge clk);
    @(negedge clk); bus_we = 1'b1; bus_addr = 8'h1C; bus_wdata = 32'h01;
    @(negedge clk); bus_we = 1'b0;
    rdchk("R10 rise vs clear", 8'h1C, 32'h01);
    wr(8'h1C, 32'h01); rdchk("R10 later clear", 8'h1C, 32'h0);
    @(negedge clk); pins = 8'h00;
    @(posedge clk); @(posedge clk);
    @(negedge clk); bus_we = 1'b1; bus_addr = 8'h24; bus_wdata = 32'h01;
    @(negedge clk); bus_we = 1'b0;
    rdchk("R10 fall vs status clear", 8'h20, 32'h01);
    chk("R10 irq", {24'h0, irq}, 32'h01);

    // R11: unmapped offsets
    wr(8'h28, 32'hFF); wr(8'h3C, 32'hFF);
    rdchk("R11 read", 8'h28, 32'h0);
    rdchk("R11 read", 8'h3C, 32'h0);
    rdchk("R11 mode kept", 8'h00, 32'h0);
    rdchk("R11 en kept", 8'h10, 32'h01);

    summary();
  end
endmodule